// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small, fully associative cache of page translations for 8 KiB pages. Each slot remembers a virtual page tag, the address-space number that owns it, a global flag, a physical page number, two four-bit enable masks (one bit per privilege mode, for reads and for writes), and two trap flags: one for reads and one for writes. A lookup presents a virtual page number, the current address-space number, the 13-bit page offset and an instruction-fetch flag. In the same cycle the block returns a hit flag, the matching slot's index and fields, and the composed physical address. Permission checking, fault generation and table walking belong to the consumer.

A single command port changes the contents. It can load a new translation into the slot named by a rotating victim pointer. It can also drop every translation, drop only the non-global translations, or drop one page in one address space. Commands take effect on the clock edge, so a lookup made in the same cycle still sees the old contents. The slot count is a parameter, `ENTRIES`.

Top module: `asn_tlb`

## Requirements
- R1: A slot hits only when it is valid, its tag equals `lk_vpn`, and either its global flag is set or its stored address-space number equals `lk_asn`.
- R2: Command code 1 (insert) writes `cmd_vpn`, `cmd_asn` and the `new_*` fields into the slot named by the victim pointer and overwrites any valid translation there. The pointer then advances by one and wraps from `ENTRIES-1` to 0.
- R3: Command code 2 (flush all) clears every valid bit and returns the victim pointer to slot 0.
- R4: Command code 3 (flush non-global) drops every valid slot whose global flag is clear and keeps every global slot.
- R5: Command code 4 (flush page) drops every valid slot whose tag equals `cmd_vpn` and whose global flag is set or whose address-space number equals `cmd_asn`.
- R6: On a hit, `pa` is `hit_ppn` concatenated above the 13-bit `lk_offset`. When `lk_ifetch` is high, bits 1:0 of `pa` are zero.
- R7: When several slots match, the lowest-indexed one is reported.
- R8: Commands update on the rising clock edge. A lookup in the same cycle as a command returns the contents from before that command.
- R9: Reset leaves the block in the flush-all state: no slot valid and the victim pointer at slot 0.
- R10: On a miss, every hit field and `pa` are zero. Command codes 5, 6 and 7 change neither the contents nor the victim pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vpn | input | 30 | Lookup virtual page number |
| lk_asn | input | 8 | Lookup address-space number |
| lk_offset | input | 13 | Lookup page offset |
| lk_ifetch | input | 1 | Lookup is an instruction fetch |
| cmd_op | input | 3 | Command: 0 idle, 1 insert, 2 flush all, 3 flush non-global, 4 flush page |
| cmd_vpn | input | 30 | Page number for insert or flush page |
| cmd_asn | input | 8 | Address-space number for insert or flush page |
| new_glob | input | 1 | Global flag of the inserted slot |
| new_ppn | input | 28 | Physical page of the inserted slot |
| new_rd_en | input | 4 | Per-mode read enables of the inserted slot |
| new_wr_en | input | 4 | Per-mode write enables of the inserted slot |
| new_fonr | input | 1 | Trap-on-read flag of the inserted slot |
| new_fonw | input | 1 | Trap-on-write flag of the inserted slot |
| hit | output | 1 | Lookup matched a slot |
| hit_idx | output | $clog2(ENTRIES) | Index of the reported slot |
| hit_glob | output | 1 | Global flag of the reported slot |
| hit_ppn | output | 28 | Physical page of the reported slot |
| hit_rd_en | output | 4 | Read enables of the reported slot |
| hit_wr_en | output | 4 | Write enables of the reported slot |
| hit_fonr | output | 1 | Trap-on-read flag of the reported slot |
| hit_fonw | output | 1 | Trap-on-write flag of the reported slot |
| pa | output | 41 | Composed physical address |

## Verification
The bench checks that a global slot answers under a foreign address-space number while a private slot does not. A design that compared the number unconditionally would miss the first case, and one that skipped the comparison would hit the second. It loads the same page twice and expects the older, lower slot to be reported; a design with reversed priority would return the newer page. It fills the buffer one past its size to check that the pointer wraps, and it checks that flush page removes a global slot under any number while sparing a private slot of the same page that belongs to another space. It also checks that a lookup made in the same cycle as an insert or a flush still sees the old contents, and that the unused command codes move neither the contents nor the pointer.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
    localparam int VPN_W    = 30;
    localparam int ASN_W    = 8;
    localparam int PPN_W    = 28;
    localparam int PG_SHIFT = 13;
    localparam int N_MODES  = 4;
    localparam int PA_W     = PPN_W + PG_SHIFT;

    typedef enum logic [2:0] {
        OP_IDLE       = 3'd0,
        OP_INSERT     = 3'd1,
        OP_FLUSH_ALL  = 3'd2,
        OP_FLUSH_PROC = 3'd3,
        OP_FLUSH_PAGE = 3'd4
    } tlb_op_e;

    typedef struct packed {
        logic [VPN_W-1:0]   tag;
        logic [ASN_W-1:0]   asn;
        logic               glob;
        logic [PPN_W-1:0]   ppn;
        logic [N_MODES-1:0] rd_en;
        logic [N_MODES-1:0] wr_en;
        logic               fonr;
        logic               fonw;
    } tlb_ent_t;
endpackage

// File: rtl/tlbx_match.sv
module tlbx_match
    import tlbx_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic [ENTRIES-1:0]           valid,
    input  tlb_ent_t [ENTRIES-1:0]       ents,
    input  logic [VPN_W-1:0]             vpn,
    input  logic [ASN_W-1:0]             asn,
    output logic [ENTRIES-1:0]           match
);
    // One comparator per slot; the global flag bypasses the space compare.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic tag_eq;
        logic asn_ok;
        assign tag_eq   = (ents[g].tag == vpn);
        assign asn_ok   = ents[g].glob || (ents[g].asn == asn);
        assign match[g] = valid[g] && tag_eq && asn_ok;
    end
endmodule

// File: rtl/tlbx_pick.sv
module tlbx_pick #(
    parameter  int ENTRIES = 8,
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] req,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);
    // Scan from the top down so the lowest set bit is the last one written.
    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
        any = |req;
    end

    logic [ENTRIES-1:0] below_mask;
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) below_mask[i] = (IDX_W'(i) < idx);
    end

    // R7: the reported slot is requesting and nothing below it is
    a_r7_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (req[idx] && ((req & below_mask) == '0)));
endmodule

// File: rtl/tlbx_store.sv
module tlbx_store
    import tlbx_pkg::*;
#(
    parameter  int ENTRIES = 8,
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  tlb_op_e                op,
    input  tlb_ent_t               new_ent,
    input  logic [ENTRIES-1:0]     page_match,
    output logic [ENTRIES-1:0]     valid_q,
    output tlb_ent_t [ENTRIES-1:0] ent_q
);
    logic [IDX_W-1:0]   ptr_q, ptr_d;
    logic [ENTRIES-1:0] valid_d;
    logic [ENTRIES-1:0] glob_vec;
    logic               load;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_glob
        assign glob_vec[g] = ent_q[g].glob;
    end

    // Next-state decode of the command
    always_comb begin
        valid_d = valid_q;
        ptr_d   = ptr_q;
        load    = 1'b0;
        unique case (op)
            OP_INSERT: begin
                valid_d[ptr_q] = 1'b1;
                load           = 1'b1;
                ptr_d          = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
            end
            OP_FLUSH_ALL: begin
                valid_d = '0;
                ptr_d   = '0;
            end
            OP_FLUSH_PROC: valid_d = valid_q & glob_vec;
            OP_FLUSH_PAGE: valid_d = valid_q & ~page_match;
            default: ;
        endcase
    end

    // State register: valid bits and victim pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            ptr_q   <= '0;
        end else begin
            valid_q <= valid_d;
            ptr_q   <= ptr_d;
        end
    end

    // Slot payload, qualified by the valid bits
    always_ff @(posedge clk) begin
        if (load) ent_q[ptr_q] <= new_ent;
    end

    a_r2_insert_sets_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_INSERT) |=> valid_q[$past(ptr_q)]);
    a_r2_ptr_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_INSERT && ptr_q == LAST) |=> (ptr_q == '0));
    a_r3_flush_all_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_FLUSH_ALL) |=> (valid_q == '0 && ptr_q == '0));
    a_r4_proc_drops_private: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_FLUSH_PROC) |=> ((valid_q & ~glob_vec) == '0));
    a_r4_proc_keeps_global: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_FLUSH_PROC) |=> (valid_q == $past(valid_q & glob_vec)));
    a_r5_page_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_FLUSH_PAGE) |=> ((valid_q & $past(page_match)) == '0));
endmodule

// File: rtl/asn_tlb.sv
module asn_tlb
    import tlbx_pkg::*;
#(
    parameter  int ENTRIES = 8,
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [VPN_W-1:0]     lk_vpn,
    input  logic [ASN_W-1:0]     lk_asn,
    input  logic [PG_SHIFT-1:0]  lk_offset,
    input  logic                 lk_ifetch,
    input  logic [2:0]           cmd_op,
    input  logic [VPN_W-1:0]     cmd_vpn,
    input  logic [ASN_W-1:0]     cmd_asn,
    input  logic                 new_glob,
    input  logic [PPN_W-1:0]     new_ppn,
    input  logic [N_MODES-1:0]   new_rd_en,
    input  logic [N_MODES-1:0]   new_wr_en,
    input  logic                 new_fonr,
    input  logic                 new_fonw,
    output logic                 hit,
    output logic [IDX_W-1:0]     hit_idx,
    output logic                 hit_glob,
    output logic [PPN_W-1:0]     hit_ppn,
    output logic [N_MODES-1:0]   hit_rd_en,
    output logic [N_MODES-1:0]   hit_wr_en,
    output logic                 hit_fonr,
    output logic                 hit_fonw,
    output logic [PA_W-1:0]      pa
);
    tlb_op_e                op;
    tlb_ent_t               new_ent;
    logic [ENTRIES-1:0]     valid_q;
    tlb_ent_t [ENTRIES-1:0] ent_q;
    logic [ENTRIES-1:0]     lk_match;
    logic [ENTRIES-1:0]     pg_match;
    logic                   any;
    logic [IDX_W-1:0]       sel;
    tlb_ent_t               sel_ent;
    logic [PG_SHIFT-1:0]    offs;

    assign op = tlb_op_e'(cmd_op);

    always_comb begin
        new_ent       = '0;
        new_ent.tag   = cmd_vpn;
        new_ent.asn   = cmd_asn;
        new_ent.glob  = new_glob;
        new_ent.ppn   = new_ppn;
        new_ent.rd_en = new_rd_en;
        new_ent.wr_en = new_wr_en;
        new_ent.fonr  = new_fonr;
        new_ent.fonw  = new_fonw;
    end

    tlbx_store #(.ENTRIES(ENTRIES)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .new_ent    (new_ent),
        .page_match (pg_match),
        .valid_q    (valid_q),
        .ent_q      (ent_q)
    );

    // Lookup comparators
    tlbx_match #(.ENTRIES(ENTRIES)) u_lk_cmp (
        .valid (valid_q),
        .ents  (ent_q),
        .vpn   (lk_vpn),
        .asn   (lk_asn),
        .match (lk_match)
    );

    // Flush-page comparators share the same matching rule
    tlbx_match #(.ENTRIES(ENTRIES)) u_pg_cmp (
        .valid (valid_q),
        .ents  (ent_q),
        .vpn   (cmd_vpn),
        .asn   (cmd_asn),
        .match (pg_match)
    );

    tlbx_pick #(.ENTRIES(ENTRIES)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (lk_match),
        .any   (any),
        .idx   (sel)
    );

    // Output stage: gate every field to zero on a miss
    always_comb begin
        sel_ent   = ent_q[sel];
        offs      = lk_ifetch ? {lk_offset[PG_SHIFT-1:2], 2'b00} : lk_offset;
        hit       = any;
        hit_idx   = any ? sel : '0;
        hit_glob  = any & sel_ent.glob;
        hit_ppn   = any ? sel_ent.ppn : '0;
        hit_rd_en = any ? sel_ent.rd_en : '0;
        hit_wr_en = any ? sel_ent.wr_en : '0;
        hit_fonr  = any & sel_ent.fonr;
        hit_fonw  = any & sel_ent.fonw;
        pa        = any ? {sel_ent.ppn, offs} : '0;
    end

    a_r6_fetch_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && lk_ifetch) |-> (pa[1:0] == 2'b00));
    a_r6_page_above_offset: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (pa[PA_W-1:PG_SHIFT] == hit_ppn));
    a_r10_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (pa == '0 && hit_ppn == '0 && hit_idx == '0));
    a_r1_hit_matches: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (valid_q[hit_idx] && ent_q[hit_idx].tag == lk_vpn
                 && (ent_q[hit_idx].glob || ent_q[hit_idx].asn == lk_asn)));
    a_r9_reset_empty: assert property (@(posedge clk)
        !rst_n |=> (valid_q == '0));
endmodule

// File: tb/test_asn_tlb.sv
module test_asn_tlb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [29:0] lk_vpn;
    logic [7:0]  lk_asn;
    logic [12:0] lk_offset;
    logic        lk_ifetch;
    logic [2:0]  cmd_op;
    logic [29:0] cmd_vpn;
    logic [7:0]  cmd_asn;
    logic        new_glob;
    logic [27:0] new_ppn;
    logic [3:0]  new_rd_en, new_wr_en;
    logic        new_fonr, new_fonw;
    logic        hit;
    logic [2:0]  hit_idx;
    logic        hit_glob;
    logic [27:0] hit_ppn;
    logic [3:0]  hit_rd_en, hit_wr_en;
    logic        hit_fonr, hit_fonw;
    logic [40:0] pa;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    asn_tlb i_asn_tlb (
        .clk(clk), .rst_n(rst_n),
        .lk_vpn(lk_vpn), .lk_asn(lk_asn), .lk_offset(lk_offset), .lk_ifetch(lk_ifetch),
        .cmd_op(cmd_op), .cmd_vpn(cmd_vpn), .cmd_asn(cmd_asn),
        .new_glob(new_glob), .new_ppn(new_ppn), .new_rd_en(new_rd_en),
        .new_wr_en(new_wr_en), .new_fonr(new_fonr), .new_fonw(new_fonw),
        .hit(hit), .hit_idx(hit_idx), .hit_glob(hit_glob), .hit_ppn(hit_ppn),
        .hit_rd_en(hit_rd_en), .hit_wr_en(hit_wr_en), .hit_fonr(hit_fonr),
        .hit_fonw(hit_fonw), .pa(pa)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present a command for one clock edge; returns at a falling edge.
    task automatic do_cmd(input logic [2:0] op, input logic [29:0] v, input logic [7:0] a,
                          input logic g, input logic [27:0] p);
        @(negedge clk);
        cmd_op = op; cmd_vpn = v; cmd_asn = a; new_glob = g; new_ppn = p;
        new_rd_en = p[3:0]; new_wr_en = ~p[3:0]; new_fonr = p[0]; new_fonw = p[1];
        @(negedge clk);
        cmd_op = 3'd0;
    endtask

    task automatic ins(input logic [29:0] v, input logic [7:0] a, input logic g, input logic [27:0] p);
        do_cmd(3'd1, v, a, g, p);
    endtask

    task automatic flush_all();
        do_cmd(3'd2, '0, '0, 1'b0, '0);
    endtask

    task automatic look(input logic [29:0] v, input logic [7:0] a, input logic [12:0] off, input logic f);
        lk_vpn = v; lk_asn = a; lk_offset = off; lk_ifetch = f;
        #1;
    endtask

    task automatic expect_hit(input string req, input logic [29:0] v, input logic [7:0] a,
                              input logic [2:0] idx, input logic [27:0] p);
        look(v, a, 13'h0abc, 1'b0);
        chk({req, " hit"}, 64'(hit), 64'd1);
        chk({req, " idx"}, 64'(hit_idx), 64'(idx));
        chk({req, " ppn"}, 64'(hit_ppn), 64'(p));
        chk({req, " pa"}, 64'(pa), 64'({p, 13'h0abc}));
    endtask

    task automatic expect_miss(input string req, input logic [29:0] v, input logic [7:0] a);
        look(v, a, 13'h0abc, 1'b0);
        chk({req, " miss"}, 64'(hit), 64'd0);
        chk({req, " miss pa zero"}, 64'(pa), 64'd0);
        chk({req, " miss fields zero"}, 64'({hit_idx, hit_ppn, hit_rd_en, hit_glob}), 64'd0);
    endtask

    task automatic t_reset();
        expect_miss("R9 empty after reset", 30'd0, 8'd0);
        ins(30'd5, 8'd0, 1'b0, 28'h5);
        expect_hit("R9 pointer at zero", 30'd5, 8'd0, 3'd0, 28'h5);
    endtask

    task automatic t_match();
        flush_all();
        ins(30'd10, 8'd3, 1'b0, 28'h111);
        ins(30'd20, 8'd1, 1'b1, 28'h222);
        expect_hit("R1 private own space", 30'd10, 8'd3, 3'd0, 28'h111);
        expect_miss("R1 private other space", 30'd10, 8'd4);
        expect_miss("R1 tag differs", 30'd11, 8'd3);
        expect_hit("R1 global any space", 30'd20, 8'd200, 3'd1, 28'h222);
        chk("R1 global flag out", 64'(hit_glob), 64'd1);
        chk("R1 read enables out", 64'(hit_rd_en), 64'h2);
        chk("R1 write enables out", 64'(hit_wr_en), 64'hd);
        chk("R1 trap flags out", 64'({hit_fonr, hit_fonw}), 64'b01);
    endtask

    task automatic t_pa();
        look(30'd10, 8'd3, 13'h1fff, 1'b0);
        chk("R6 data pa", 64'(pa), 64'({28'h111, 13'h1fff}));
        look(30'd10, 8'd3, 13'h1fff, 1'b1);
        chk("R6 fetch pa low bits", 64'(pa), 64'({28'h111, 13'h1ffc}));
    endtask

    task automatic t_prio();
        ins(30'd10, 8'd3, 1'b0, 28'h333);
        expect_hit("R7 lowest slot wins", 30'd10, 8'd3, 3'd0, 28'h111);
    endtask

    task automatic t_same_cycle();
        flush_all();
        @(negedge clk);
        cmd_op = 3'd1; cmd_vpn = 30'd40; cmd_asn = 8'd0; new_glob = 1'b0; new_ppn = 28'h55;
        look(30'd40, 8'd0, 13'h0abc, 1'b0);
        chk("R8 insert not visible same cycle", 64'(hit), 64'd0);
        @(negedge clk);
        cmd_op = 3'd0;
        #1;
        chk("R8 insert visible after edge", 64'(hit), 64'd1);
        @(negedge clk);
        cmd_op = 3'd2;
        #1;
        chk("R8 flush not visible same cycle", 64'(hit), 64'd1);
        @(negedge clk);
        cmd_op = 3'd0;
        #1;
        chk("R8 flush visible after edge", 64'(hit), 64'd0);
    endtask

    task automatic t_wrap();
        flush_all();
        for (int i = 0; i < 9; i++) ins(30'(100 + i), 8'd0, 1'b0, 28'(12'h900 + i));
        expect_miss("R2 overwritten slot", 30'd100, 8'd0);
        expect_hit("R2 wrap to slot 0", 30'd108, 8'd0, 3'd0, 28'h908);
        expect_hit("R2 slot 1 kept", 30'd101, 8'd0, 3'd1, 28'h901);
        expect_hit("R2 last slot", 30'd107, 8'd0, 3'd7, 28'h907);
    endtask

    task automatic t_flush_all();
        flush_all();
        expect_miss("R3 cleared a", 30'd108, 8'd0);
        expect_miss("R3 cleared b", 30'd101, 8'd0);
        ins(30'd50, 8'd0, 1'b0, 28'h50);
        expect_hit("R3 pointer reset", 30'd50, 8'd0, 3'd0, 28'h50);
    endtask

    task automatic t_flush_proc();
        flush_all();
        ins(30'd60, 8'd1, 1'b0, 28'h60);
        ins(30'd61, 8'd1, 1'b1, 28'h61);
        ins(30'd62, 8'd2, 1'b0, 28'h62);
        do_cmd(3'd3, '0, '0, 1'b0, '0);
        expect_miss("R4 private dropped a", 30'd60, 8'd1);
        expect_miss("R4 private dropped b", 30'd62, 8'd2);
        expect_hit("R4 global kept", 30'd61, 8'd77, 3'd1, 28'h61);
    endtask

    task automatic t_flush_page();
        flush_all();
        ins(30'd70, 8'd1, 1'b0, 28'h701);
        ins(30'd70, 8'd2, 1'b0, 28'h702);
        ins(30'd71, 8'd1, 1'b1, 28'h71);
        ins(30'd72, 8'd1, 1'b0, 28'h72);
        do_cmd(3'd4, 30'd70, 8'd1, 1'b0, '0);
        expect_miss("R5 page in space dropped", 30'd70, 8'd1);
        expect_hit("R5 same page other space kept", 30'd70, 8'd2, 3'd1, 28'h702);
        expect_hit("R5 other page kept", 30'd72, 8'd1, 3'd3, 28'h72);
        do_cmd(3'd4, 30'd71, 8'd9, 1'b0, '0);
        expect_miss("R5 global page dropped by any space", 30'd71, 8'd1);
        do_cmd(3'd4, 30'd72, 8'd2, 1'b0, '0);
        expect_hit("R5 private page other space spared", 30'd72, 8'd1, 3'd3, 28'h72);
    endtask

    task automatic t_unused_ops();
        flush_all();
        ins(30'd80, 8'd0, 1'b0, 28'h80);
        for (int op = 5; op < 8; op++) do_cmd(3'(op), 30'd80, 8'd0, 1'b1, 28'hfff);
        expect_hit("R10 unused code keeps slot", 30'd80, 8'd0, 3'd0, 28'h80);
        ins(30'd81, 8'd0, 1'b0, 28'h81);
        expect_hit("R10 unused code keeps pointer", 30'd81, 8'd0, 3'd1, 28'h81);
        expect_miss("R10 miss outputs zero", 30'd99, 8'd0);
    endtask

    initial begin
        rst_n = 1'b0;
        lk_vpn = '0; lk_asn = '0; lk_offset = '0; lk_ifetch = 1'b0;
        cmd_op = '0; cmd_vpn = '0; cmd_asn = '0; new_glob = 1'b0; new_ppn = '0;
        new_rd_en = '0; new_wr_en = '0; new_fonr = 1'b0; new_fonw = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_match();
        t_pa();
        t_prio();
        t_same_cycle();
        t_wrap();
        t_flush_all();
        t_flush_proc();
        t_flush_page();
        t_unused_ops();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule